// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Registers

This block performs 32x32 multiplies and 32/32 divides, signed or unsigned, in the background of a processor pipeline. An operation is issued with a single-cycle start strobe carrying an operation code and two operands. The unit accepts it at once and works on it over the following cycles. Results land in two result registers, HI and LO. A multiply leaves the 64-bit product split across them, upper half in HI. A divide leaves the quotient in LO and the remainder in HI.

A consumer reads HI or LO by raising a read request. While an operation is still in flight, the read is held off with a stall output until the result has been written. Both registers can also be loaded directly through write strobes. Division never traps. Divide-by-zero and the one signed overflow case give fixed, documented results. A new start aborts any operation still in flight. A direct write made while busy is deferred until the operation finishes, so the written value wins over that half of the result.

The read path is a plain request/stall pair rather than valid/ready. A requester holds its request high while `rd_stall` is high and takes `rd_data` in the first cycle in which `rd_stall` is low. The start and write strobes are never back-pressured.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero and `busy` is low.
- R2: `op_code` 2'b00 is a signed multiply and 2'b01 an unsigned multiply. When the operation completes, HI holds bits 63:32 and LO bits 31:0 of the 64-bit product of `op_a` and `op_b`.
- R3: `op_code` 2'b10 is a signed divide and 2'b11 an unsigned divide, with `op_a` the dividend and `op_b` the divisor. LO receives the quotient and HI the remainder. A signed quotient truncates toward zero and a signed remainder takes the sign of the dividend.
- R4: An unsigned divide by zero gives HI = dividend and LO = 32'hFFFFFFFF.
- R5: A signed divide by zero gives HI = dividend. LO is 32'hFFFFFFFF (-1) for a non-negative dividend and 32'h00000001 for a negative one.
- R6: A signed divide of 32'h80000000 by 32'hFFFFFFFF gives HI = 0 and LO = 32'h80000000.
- R7: After the clock edge that accepts a start, `busy` stays high for exactly MUL_LAT cycles for a multiply (default 4) and WIDTH cycles for a divide (default 32), and the result is visible once `busy` falls.
- R8: A read request (`rd_hi_req` selects HI and has priority, otherwise `rd_lo_req` selects LO) raises `rd_stall` for every cycle `busy` is high. When not stalled, `rd_data` carries the selected register.
- R9: With the unit idle and no start, a write strobe loads `wr_data` into HI (`wr_hi`) or LO (`wr_lo`) at the next edge, leaving the other register unchanged.
- R10: A write strobe given while busy, or in the cycle of a start, takes effect when the operation completes and replaces that half of the result. The other half receives the result normally.
- R11: A start while busy abandons the running operation without writing its result. The new operation runs its full latency from its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start strobe for one operation |
| op_code | input | 2 | Bit 1: divide; bit 0: unsigned |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| rd_hi_req | input | 1 | Request to read HI |
| rd_lo_req | input | 1 | Request to read LO |
| rd_stall | output | 1 | Read must wait; result not yet written |
| rd_data | output | 32 | Selected register value |
| wr_hi | input | 1 | Direct write strobe for HI |
| wr_lo | input | 1 | Direct write strobe for LO |
| wr_data | input | 32 | Data for a direct write |
| busy | output | 1 | An operation is in flight |

## Verification
The hardest situations to reach from the ports are those where two events overlap inside one operation's lifetime. One is a direct write landing mid-divide, which must survive the later result write. The other is a second start arriving a cycle into a multiply, which must suppress the first result and restart the count. The stimulus places these strobes on exact cycles relative to the start and then counts stalled read cycles to confirm the restarted latency. Random operations with operands biased toward zero, -1 and the most negative value add to directed cases for every divide special result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  // bit 1 selects divide, bit 0 selects unsigned
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(LAT + 1);
  localparam int PW = 2 * W + 2;

  logic [CW-1:0]       cnt_q;
  logic [2*W-1:0]      prod_q;
  logic signed [W:0]   ext_a, ext_b;
  logic signed [PW-1:0] full;

  assign ext_a = {is_signed & a[W-1], a};
  assign ext_b = {is_signed & b[W-1], b};
  assign full  = PW'(ext_a) * PW'(ext_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      prod_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
      prod_q <= full[2*W-1:0];
    end else if (abort) begin
      active <= 1'b0;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done    = active && (cnt_q == '0) && !abort;
  assign prod_hi = prod_q[2*W-1:W];
  assign prod_lo = prod_q[W-1:0];
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         done,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          negq_q, negr_q;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    shifted, trial;
  logic          fits;
  logic [W-1:0]  rem_n, quo_n;

  assign a_mag = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
  assign b_mag = (is_signed && b[W-1]) ? (~b + 1'b1) : b;

  // one restoring step per cycle
  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign fits    = !trial[W];
  assign rem_n   = fits ? trial[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo_q[W-2:0], fits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= CW'(W - 1);
      rem_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      negq_q <= is_signed && (a[W-1] ^ b[W-1]);
      negr_q <= is_signed && a[W-1];
    end else if (abort) begin
      active <= 1'b0;
    end else if (active) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done    = active && (cnt_q == '0) && !abort;
  assign quo_out = negq_q ? (~quo_n + 1'b1) : quo_n;
  assign rem_out = negr_q ? (~rem_n + 1'b1) : rem_n;
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         res_we,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic         phi_v, plo_v;
  logic [W-1:0] phi_q, plo_q;
  logic         phi_vn, plo_vn;
  logic [W-1:0] phi_n, plo_n;

  // deferred writes, newest strobe wins
  always_comb begin
    phi_vn = phi_v | (hold & wr_hi);
    plo_vn = plo_v | (hold & wr_lo);
    phi_n  = (hold & wr_hi) ? wr_data : phi_q;
    plo_n  = (hold & wr_lo) ? wr_data : plo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi    <= '0;
      lo    <= '0;
      phi_v <= 1'b0;
      plo_v <= 1'b0;
      phi_q <= '0;
      plo_q <= '0;
    end else if (res_we) begin
      hi    <= phi_vn ? phi_n : res_hi;
      lo    <= plo_vn ? plo_n : res_lo;
      phi_v <= 1'b0;
      plo_v <= 1'b0;
    end else if (hold) begin
      phi_v <= phi_vn;
      plo_v <= plo_vn;
      phi_q <= phi_n;
      plo_q <= plo_n;
    end else begin
      if (wr_hi) hi <= wr_data;
      if (wr_lo) lo <= wr_data;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH   = 32,
  parameter int MUL_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [1:0]       op_code,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             rd_hi_req,
  input  logic             rd_lo_req,
  output logic             rd_stall,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [WIDTH-1:0] wr_data,
  output logic             busy
);
  import mdu_pkg::*;

  mdu_op_e          op;
  logic             is_div, is_signed;
  logic             mul_active, mul_done, div_active, div_done;
  logic [WIDTH-1:0] mul_hi, mul_lo, div_quo, div_rem;
  logic [WIDTH-1:0] hi_val, lo_val;
  logic             res_we;
  logic [WIDTH-1:0] res_hi, res_lo;

  assign op        = mdu_op_e'(op_code);
  assign is_div    = (op == OP_DIV_S) || (op == OP_DIV_U);
  assign is_signed = (op == OP_MUL_S) || (op == OP_DIV_S);

  mdu_mul #(.W(WIDTH), .LAT(MUL_LAT)) mul_i (
    .clk(clk), .rst_n(rst_n),
    .start(op_start && !is_div), .abort(op_start),
    .is_signed(is_signed), .a(op_a), .b(op_b),
    .active(mul_active), .done(mul_done),
    .prod_hi(mul_hi), .prod_lo(mul_lo)
  );

  mdu_div #(.W(WIDTH)) div_i (
    .clk(clk), .rst_n(rst_n),
    .start(op_start && is_div), .abort(op_start),
    .is_signed(is_signed), .a(op_a), .b(op_b),
    .active(div_active), .done(div_done),
    .quo_out(div_quo), .rem_out(div_rem)
  );

  assign busy   = mul_active | div_active;
  assign res_we = mul_done | div_done;
  assign res_hi = div_done ? div_rem : mul_hi;
  assign res_lo = div_done ? div_quo : mul_lo;

  mdu_hilo #(.W(WIDTH)) hilo_i (
    .clk(clk), .rst_n(rst_n),
    .hold(busy | op_start),
    .res_we(res_we), .res_hi(res_hi), .res_lo(res_lo),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .hi(hi_val), .lo(lo_val)
  );

  assign rd_stall = (rd_hi_req | rd_lo_req) & busy;
  assign rd_data  = rd_hi_req ? hi_val : lo_val;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_start,
  input logic         busy,
  input logic         rd_stall,
  input logic         rd_hi_req,
  input logic         rd_lo_req,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_val,
  input logic [W-1:0] lo_val,
  input logic         mul_active,
  input logic         div_active,
  input logic         mul_done,
  input logic         div_done
);
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);

  assert_stall_has_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (busy && (rd_hi_req || rd_lo_req)));

  assert_idle_hi_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_start && !wr_hi) |=> $stable(hi_val));

  assert_idle_lo_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_start && wr_lo) |=> (lo_val == $past(wr_data)));

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mul_done && !div_done) |=> ($stable(hi_val) && $stable(lo_val)));

  assert_single_unit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_active && div_active));
endmodule

bind muldiv_unit mdu_checker #(.W(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .busy(busy),
  .rd_stall(rd_stall), .rd_hi_req(rd_hi_req), .rd_lo_req(rd_lo_req),
  .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
  .hi_val(hi_val), .lo_val(lo_val),
  .mul_active(mul_active), .div_active(div_active),
  .mul_done(mul_done), .div_done(div_done)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  localparam int MLAT = 4;
  localparam int DLAT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [31:0] op_a = '0, op_b = '0;
  logic        rd_hi_req = 1'b0, rd_lo_req = 1'b0;
  logic        rd_stall;
  logic [31:0] rd_data;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .rd_hi_req(rd_hi_req), .rd_lo_req(rd_lo_req),
    .rd_stall(rd_stall), .rd_data(rd_data), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .busy(busy)
  );

  function automatic logic [63:0] ref_result(input logic [1:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
    logic signed [63:0] sp;
    logic signed [31:0] sq, sr;
    if (op == 2'b01) return {32'b0, a} * {32'b0, b};
    if (op == 2'b00) begin
      sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
      return sp;
    end
    if (op == 2'b11) begin
      if (b == 0) return {a, 32'hFFFFFFFF};
      return {a % b, a / b};
    end
    if (b == 0) return {a, (a[31] ? 32'h1 : 32'hFFFFFFFF)};
    if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'h0, 32'h80000000};
    sq = $signed(a) / $signed(b);
    sr = $signed(a) % $signed(b);
    return {sr, sq};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // at a negedge with the unit idle: read both registers
  task automatic read_regs(output logic [31:0] h, output logic [31:0] l);
    rd_hi_req = 1; rd_lo_req = 0; #1 h = rd_data;
    rd_hi_req = 0; rd_lo_req = 1; #1 l = rd_data;
    rd_lo_req = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_start = 1; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    op_start = 0;
  endtask

  // from a negedge: count stalled cycles of a held read request
  task automatic count_stall(output int n);
    n = 0;
    rd_hi_req = 1;
    #1;
    while (rd_stall && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    rd_hi_req = 0;
    @(negedge clk);
  endtask

  task automatic run_op(input string req, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b, input bit chk_lat);
    int n;
    logic [63:0] e;
    logic [31:0] h, l;
    e = ref_result(op, a, b);
    issue(op, a, b);
    count_stall(n);
    if (chk_lat) chk("R7 latency", n, op[1] ? DLAT : MLAT);
    read_regs(h, l);
    chk({req, " HI"}, h, e[63:32]);
    chk({req, " LO"}, l, e[31:0]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] h, l, wa, wb;
    int n;
    $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    read_regs(h, l);
    chk("R1 HI", h, 0);
    chk("R1 LO", l, 0);

    // R2 multiplies
    run_op("R2 smul", 2'b00, 32'hFFFFFFFD, 32'h00000007, 1);
    run_op("R2 umul", 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);
    run_op("R2 smul minmin", 2'b00, 32'h80000000, 32'h80000000, 0);
    // R3 divides
    run_op("R3 sdiv", 2'b10, 32'hFFFFFFF9, 32'h00000002, 1);
    run_op("R3 sdiv negdvs", 2'b10, 32'h00000007, 32'hFFFFFFFE, 0);
    run_op("R3 udiv", 2'b11, 32'hFFFFFFF9, 32'h00000002, 1);
    // R4 R5 R6 special cases
    run_op("R4 udiv0", 2'b11, 32'h89ABCDEF, 32'h0, 0);
    run_op("R5 sdiv0 pos", 2'b10, 32'h12345678, 32'h0, 0);
    run_op("R5 sdiv0 neg", 2'b10, 32'h87654321, 32'h0, 0);
    run_op("R6 sdiv ovf", 2'b10, 32'h80000000, 32'hFFFFFFFF, 0);

    // R8 read on the first busy cycle stalls, data after
    issue(2'b01, 32'd6, 32'd7);
    rd_lo_req = 1; #1;
    chk("R8 stall", rd_stall, 1);
    rd_lo_req = 0;
    count_stall(n);
    rd_lo_req = 1; #1;
    chk("R8 stall low", rd_stall, 0);
    chk("R8 data", rd_data, 32'd42);
    rd_lo_req = 0;

    // R9 idle direct writes
    @(negedge clk);
    wr_lo = 1; wr_data = 32'hCAFEF00D;
    @(negedge clk);
    wr_lo = 0; wr_hi = 1; wr_data = 32'h0BADBEEF;
    @(negedge clk);
    wr_hi = 0;
    read_regs(h, l);
    chk("R9 LO", l, 32'hCAFEF00D);
    chk("R9 HI", h, 32'h0BADBEEF);

    // R10 write during busy overrides that half only
    issue(2'b11, 32'd100, 32'd7);
    wr_hi = 1; wr_data = 32'h5555AAAA;
    @(negedge clk);
    wr_hi = 0;
    count_stall(n);
    read_regs(h, l);
    chk("R10 HI kept", h, 32'h5555AAAA);
    chk("R10 LO result", l, 32'd14);

    // R11 start while busy aborts multiply
    issue(2'b01, 32'd3, 32'd3);
    op_start = 1; op_code = 2'b11; op_a = 32'd50; op_b = 32'd8;
    @(negedge clk);
    op_start = 0;
    count_stall(n);
    chk("R11 new latency", n, DLAT);
    read_regs(h, l);
    chk("R11 HI", h, 32'd2);
    chk("R11 LO", l, 32'd6);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      wa = $urandom;
      wb = $urandom;
      case ($urandom_range(0, 5))
        0: wb = 0;
        1: wb = 32'hFFFFFFFF;
        2: wa = 32'h80000000;
        3: wb = 32'($urandom_range(1, 20));
        default: ;
      endcase
      run_op(op[1] ? "R3 random div" : "R2 random mul", op, wa, wb, 1);
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule